// File: doc/BRIEF.md
# Floating-Point Operand Unpacker

This block turns a raw memory operand into one uniform internal number that later arithmetic stages can consume without caring where the value came from. The operand arrives as up to three 32-bit words together with a 3-bit format code. The format selects one of three signed integer widths (8, 16 or 32 bits) or one of three floating widths: IEEE single, IEEE double, or a 96-bit extended format that carries its integer bit explicitly.

Every legal input is reduced to a sign, a two's-complement unbiased exponent, a wide mantissa whose leading one sits at the top bit, a sticky bit that always starts cleared, and a class code. Integers and denormals pass through a shared leading-zero normalizer. NaNs are classified as quiet or signalling. A signalling NaN is quieted on the way through and raises a status flag. With the default parameters the outputs are registered, so a result appears one clock after its operand.

Top module: `fpu_operand_unpack`

## Requirements
- R1: For every legal format, `sign_o` equals bit 31 of `word0_i`, and `sticky_o` is always 0.
- R2: Format codes are 0 byte, 1 word, 2 long, 3 single, 4 double and 5 extended. Codes 6 and 7 set `bad_fmt_o` to 1 and force every other output to 0.
- R3: Class codes are 0 zero, 1 number, 2 infinity, 3 quiet NaN and 4 signalling NaN. Zero and infinity results carry exponent 0 and mantissa 0.
- R4: An integer operand is taken from `word0_i` bits 31:24 (byte), bits 31:16 (word) or all 32 bits (long), and is sign-extended. The value 0 gives class zero. Any other value gives its magnitude, with the exponent set to floor(log2 |v|) and the leading one moved to mantissa bit MW-1.
- R5: A single or double with an exponent field that is neither 0 nor all ones gives class number. Its exponent is the field minus 127 or 1023, and its mantissa is {1, fraction, zeros}.
- R6: A single or double with a zero exponent field and a nonzero fraction starts from exponent 1-bias with no implied one and is then normalized. The result is exponent p-149 (single) or p-1074 (double), where p is the index of the top set fraction bit.
- R7: A single or double with a zero exponent field and a zero fraction gives class zero.
- R8: An all-ones exponent field gives infinity when the fraction is zero, and a NaN otherwise. For single and double the NaN mantissa is {0, fraction, zeros}; for extended it is {word1, word2}, and infinity requires both of those words to be zero.
- R9: A NaN whose mantissa bit MW-2 is clear is signalling. That bit is set in the output, the class is 4 and `snan_flag_o` is 1. Otherwise `snan_flag_o` is 0.
- R10: The extended format takes its 15-bit exponent from `word0_i` bits 30:16 with bias 16383, and its 64-bit significand from {word1, word2}. With a nonzero exponent field, the mantissa bit MW-1 is forced to 1 and the exponent is the field minus 16383. With a zero field, a zero significand gives class zero; any other significand gives exponent p-16446 after normalization.
- R11: With REG_OUT=1, outputs change one rising edge after the inputs, and an active-low reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 3 | Operand format code |
| word0_i | input | 32 | First operand word (sign, exponent, high bits) |
| word1_i | input | 32 | Second operand word |
| word2_i | input | 32 | Third operand word (extended only) |
| sign_o | output | 1 | Sign of the unpacked number |
| exp_o | output | EW | Unbiased exponent, two's complement |
| mant_o | output | MW | Mantissa, leading one at bit MW-1 for numbers |
| sticky_o | output | 1 | Sticky bit, always cleared |
| cls_o | output | 3 | Class code |
| snan_flag_o | output | 1 | Signalling-NaN status flag |
| bad_fmt_o | output | 1 | Unsupported format code |

## Verification
The assertions assume that the format code and the three operand words carry known values at every rising edge once reset is released. They also assume reset is held low across at least one edge, so the register stage starts from zero before the sign check begins comparing against the previous operand. The stimulus meets both conditions. It drives every input at the falling edge from defined constants and loop indices, never leaves a word undriven, and holds reset for several edges before the first operand.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;

   localparam int WORDW      = 32;
   localparam int BYTE_SHIFT = WORDW - 8;
   localparam int HALF_SHIFT = WORDW - 16;

   localparam int SGL_EXPW  = 8;
   localparam int SGL_FRACW = 23;
   localparam int DBL_EXPW  = 11;
   localparam int DBL_FRACW = 52;
   localparam int EXT_EXPW  = 15;
   localparam int EXT_SIGW  = 2 * WORDW;

   typedef enum logic [2:0] {
      FMT_BYTE = 3'd0,
      FMT_HALF = 3'd1,
      FMT_LONG = 3'd2,
      FMT_SGL  = 3'd3,
      FMT_DBL  = 3'd4,
      FMT_EXT  = 3'd5
   } fmt_e;

   typedef enum logic [2:0] {
      CLS_ZERO = 3'd0,
      CLS_NUM  = 3'd1,
      CLS_INF  = 3'd2,
      CLS_QNAN = 3'd3,
      CLS_SNAN = 3'd4
   } cls_e;

   function automatic int bias_of(input int expw);
      return (1 << (expw - 1)) - 1;
   endfunction

endpackage

// File: rtl/fpu_ieee_decode.sv
// Classifies one implied-leading-one IEEE format and left-justifies its
// significand. Denormals leave with exponent 1-bias, unnormalized.
module fpu_ieee_decode
   import fpu_unpack_pkg::*;
#(
   parameter int EXPW  = 8,
   parameter int FRACW = 23,
   parameter int MW    = 64,
   parameter int EW    = 18
) (
   input  logic [EXPW-1:0]  exp_fld,
   input  logic [FRACW-1:0] frac_fld,
   output cls_e             cls_o,
   output logic [EW-1:0]    exp_o,
   output logic [MW-1:0]    mant_o
);

   localparam int BIAS = bias_of(EXPW);
   localparam int PAD  = MW - 1 - FRACW;

   if (PAD < 1) begin : g_bad_mw
      $error("fpu_ieee_decode: MW too small for FRACW");
   end
   if (EW < EXPW + 2) begin : g_bad_ew
      $error("fpu_ieee_decode: EW too small for EXPW");
   end

   logic          fld_zero;
   logic          fld_ones;
   logic          frac_zero;
   logic [MW-1:0] frac_wide;

   assign fld_zero  = (exp_fld == '0);
   assign fld_ones  = &exp_fld;
   assign frac_zero = (frac_fld == '0);
   assign frac_wide = MW'(frac_fld) << PAD;

   always_comb begin
      cls_o  = CLS_ZERO;
      exp_o  = '0;
      mant_o = '0;
      if (fld_zero) begin
         if (!frac_zero) begin
            cls_o  = CLS_NUM;
            exp_o  = EW'(1 - BIAS);
            mant_o = frac_wide;
         end
      end else if (fld_ones) begin
         if (frac_zero) begin
            cls_o = CLS_INF;
         end else begin
            cls_o  = CLS_QNAN;
            mant_o = frac_wide;
         end
      end else begin
         cls_o  = CLS_NUM;
         exp_o  = EW'(int'(exp_fld) - BIAS);
         mant_o = frac_wide | {1'b1, {(MW-1){1'b0}}};
      end
   end

endmodule

// File: rtl/fpu_lzc.sv
// Leading-zero count; an all-zero vector reports W.
module fpu_lzc #(
   parameter int W  = 64,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec_i,
   output logic [CW-1:0] cnt_o
);

   if (CW < $clog2(W + 1)) begin : g_bad_cw
      $error("fpu_lzc: CW cannot hold W");
   end

   always_comb begin
      cnt_o = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (vec_i[i]) cnt_o = CW'(W - 1 - i);
      end
   end

endmodule

// File: rtl/fpu_operand_unpack.sv
module fpu_operand_unpack
   import fpu_unpack_pkg::*;
#(
   parameter int MW      = 64,
   parameter int EW      = 18,
   parameter bit REG_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    fmt_i,
   input  logic [31:0]   word0_i,
   input  logic [31:0]   word1_i,
   input  logic [31:0]   word2_i,
   output logic          sign_o,
   output logic [EW-1:0] exp_o,
   output logic [MW-1:0] mant_o,
   output logic          sticky_o,
   output logic [2:0]    cls_o,
   output logic          snan_flag_o,
   output logic          bad_fmt_o
);

   localparam int LZW      = $clog2(MW + 1);
   localparam int XBIAS    = bias_of(EXT_EXPW);
   localparam int DBL_HIW  = DBL_FRACW - WORDW;
   localparam logic [MW-1:0] QUIET_BIT = {2'b01, {(MW-2){1'b0}}};

   if (MW < EXT_SIGW) begin : g_bad_mw
      $error("fpu_operand_unpack: MW must hold the extended significand");
   end
   if (EW < EXT_EXPW + 3) begin : g_bad_ew
      $error("fpu_operand_unpack: EW too narrow for extended denormals");
   end

   // ---------------- floating formats with an implied one
   cls_e          s_cls, d_cls;
   logic [EW-1:0] s_exp, d_exp;
   logic [MW-1:0] s_mant, d_mant;

   fpu_ieee_decode #(.EXPW(SGL_EXPW), .FRACW(SGL_FRACW), .MW(MW), .EW(EW)) u_sgl (
      .exp_fld (word0_i[WORDW-2 -: SGL_EXPW]),
      .frac_fld(word0_i[SGL_FRACW-1:0]),
      .cls_o   (s_cls),
      .exp_o   (s_exp),
      .mant_o  (s_mant)
   );

   fpu_ieee_decode #(.EXPW(DBL_EXPW), .FRACW(DBL_FRACW), .MW(MW), .EW(EW)) u_dbl (
      .exp_fld (word0_i[WORDW-2 -: DBL_EXPW]),
      .frac_fld({word0_i[DBL_HIW-1:0], word1_i}),
      .cls_o   (d_cls),
      .exp_o   (d_exp),
      .mant_o  (d_mant)
   );

   // ---------------- integer path
   logic signed [WORDW-1:0] int_val;
   logic [WORDW-1:0]        int_mag;

   always_comb begin
      case (fmt_i)
         FMT_BYTE: int_val = $signed(word0_i) >>> BYTE_SHIFT;
         FMT_HALF: int_val = $signed(word0_i) >>> HALF_SHIFT;
         default:  int_val = $signed(word0_i);
      endcase
      int_mag = int_val[WORDW-1] ? WORDW'(-int_val) : WORDW'(int_val);
   end

   // ---------------- extended path (explicit integer bit)
   logic [EXT_EXPW-1:0] x_fld;
   logic [EXT_SIGW-1:0] x_sig;
   logic [MW-1:0]       x_wide;
   cls_e                x_cls;
   logic [EW-1:0]       x_exp;
   logic [MW-1:0]       x_mant;

   assign x_fld  = word0_i[WORDW-2 -: EXT_EXPW];
   assign x_sig  = {word1_i, word2_i};
   assign x_wide = MW'(x_sig) << (MW - EXT_SIGW);

   always_comb begin
      x_cls  = CLS_ZERO;
      x_exp  = '0;
      x_mant = '0;
      if (x_fld == '0) begin
         if (x_sig != '0) begin
            x_cls  = CLS_NUM;
            x_exp  = EW'(-XBIAS);
            x_mant = x_wide;
         end
      end else if (&x_fld) begin
         if (x_sig == '0) begin
            x_cls = CLS_INF;
         end else begin
            x_cls  = CLS_QNAN;
            x_mant = x_wide;
         end
      end else begin
         x_cls  = CLS_NUM;
         x_exp  = EW'(int'(x_fld) - XBIAS);
         x_mant = x_wide | {1'b1, {(MW-1){1'b0}}};
      end
   end

   // ---------------- format select
   cls_e          sel_cls;
   logic [EW-1:0] sel_exp;
   logic [MW-1:0] sel_mant;
   logic          sel_bad;

   always_comb begin
      sel_cls  = CLS_ZERO;
      sel_exp  = '0;
      sel_mant = '0;
      sel_bad  = 1'b0;
      case (fmt_i)
         FMT_BYTE, FMT_HALF, FMT_LONG: begin
            if (int_mag != '0) begin
               sel_cls  = CLS_NUM;
               sel_exp  = EW'(WORDW - 1);
               sel_mant = MW'(int_mag) << (MW - WORDW);
            end
         end
         FMT_SGL: begin
            sel_cls  = s_cls;
            sel_exp  = s_exp;
            sel_mant = s_mant;
         end
         FMT_DBL: begin
            sel_cls  = d_cls;
            sel_exp  = d_exp;
            sel_mant = d_mant;
         end
         FMT_EXT: begin
            sel_cls  = x_cls;
            sel_exp  = x_exp;
            sel_mant = x_mant;
         end
         default: sel_bad = 1'b1;
      endcase
   end

   // ---------------- shared normalizer and NaN quieting
   logic [LZW-1:0] lz_cnt;
   logic           n_sign, n_snan;
   logic [EW-1:0]  n_exp;
   logic [MW-1:0]  n_mant;
   logic [2:0]     n_cls;

   fpu_lzc #(.W(MW), .CW(LZW)) u_lzc (
      .vec_i(sel_mant),
      .cnt_o(lz_cnt)
   );

   always_comb begin
      n_sign = sel_bad ? 1'b0 : word0_i[WORDW-1];
      n_exp  = sel_exp;
      n_mant = sel_mant;
      n_cls  = sel_cls;
      n_snan = 1'b0;
      if (sel_cls == CLS_NUM) begin
         n_mant = sel_mant << lz_cnt;
         n_exp  = sel_exp - EW'(lz_cnt);
      end else if (sel_cls == CLS_QNAN && !sel_mant[MW-2]) begin
         n_mant = sel_mant | QUIET_BIT;
         n_cls  = CLS_SNAN;
         n_snan = 1'b1;
      end
   end

   // ---------------- output stage variant
   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sign_o      <= 1'b0;
            exp_o       <= '0;
            mant_o      <= '0;
            cls_o       <= '0;
            snan_flag_o <= 1'b0;
            bad_fmt_o   <= 1'b0;
         end else begin
            sign_o      <= n_sign;
            exp_o       <= n_exp;
            mant_o      <= n_mant;
            cls_o       <= n_cls;
            snan_flag_o <= n_snan;
            bad_fmt_o   <= sel_bad;
         end
      end
   end else begin : g_comb
      assign sign_o      = n_sign;
      assign exp_o       = n_exp;
      assign mant_o      = n_mant;
      assign cls_o       = n_cls;
      assign snan_flag_o = n_snan;
      assign bad_fmt_o   = sel_bad;
   end

   assign sticky_o = 1'b0;

endmodule

// File: rtl/fpu_operand_unpack_chk.sv
module fpu_operand_unpack_chk
   import fpu_unpack_pkg::*;
#(
   parameter int MW      = 64,
   parameter int EW      = 18,
   parameter bit REG_OUT = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic [31:0]   word0_i,
   input logic          sign_o,
   input logic [EW-1:0] exp_o,
   input logic [MW-1:0] mant_o,
   input logic          sticky_o,
   input logic [2:0]    cls_o,
   input logic          snan_flag_o,
   input logic          bad_fmt_o
);

   // R2
   bad_fmt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_fmt_o |-> (!sign_o && exp_o == '0 && mant_o == '0 && cls_o == 3'd0 && !snan_flag_o));

   // R1
   sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) !sticky_o);

   // R9
   snan_flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snan_flag_o == (cls_o == CLS_SNAN));

   // R9
   snan_quieted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snan_flag_o |-> mant_o[MW-2]);

   // R4
   num_leading_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_o == CLS_NUM) |-> mant_o[MW-1]);

   // R3
   zero_inf_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_o == CLS_ZERO || cls_o == CLS_INF) |-> (mant_o == '0 && exp_o == '0));

   if (REG_OUT) begin : g_reg_chk
      logic primed;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) primed <= 1'b0;
         else        primed <= 1'b1;
      end

      // R1
      sign_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (primed && !bad_fmt_o) |-> (sign_o == $past(word0_i[31])));

      // R11
      reset_clear_chk: assert property (@(posedge clk)
         !rst_n |=> (!sign_o && cls_o == 3'd0 && mant_o == '0 && !bad_fmt_o));
   end else begin : g_comb_chk
      // R1
      sign_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !bad_fmt_o |-> (sign_o == word0_i[31]));
   end

endmodule

bind fpu_operand_unpack fpu_operand_unpack_chk #(.MW(MW), .EW(EW), .REG_OUT(REG_OUT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .word0_i    (word0_i),
   .sign_o     (sign_o),
   .exp_o      (exp_o),
   .mant_o     (mant_o),
   .sticky_o   (sticky_o),
   .cls_o      (cls_o),
   .snan_flag_o(snan_flag_o),
   .bad_fmt_o  (bad_fmt_o)
);

// File: tb/sim_fpu_operand_unpack.sv
module sim_fpu_operand_unpack;

   localparam int CLK_PERIOD = 10;
   localparam int MW = 64;
   localparam int EW = 18;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [2:0]    fmt;
   logic [31:0]   w0, w1, w2;
   logic          sign_o, sticky_o, snan_flag_o, bad_fmt_o;
   logic [EW-1:0] exp_o;
   logic [MW-1:0] mant_o;
   logic [2:0]    cls_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpu_operand_unpack u0 (
      .clk(clk), .rst_n(rst_n), .fmt_i(fmt),
      .word0_i(w0), .word1_i(w1), .word2_i(w2),
      .sign_o(sign_o), .exp_o(exp_o), .mant_o(mant_o), .sticky_o(sticky_o),
      .cls_o(cls_o), .snan_flag_o(snan_flag_o), .bad_fmt_o(bad_fmt_o)
   );

   function automatic int top_bit(input logic [63:0] v);
      int p = -1;
      for (int i = 0; i < 64; i++) if (v[i]) p = i;
      return p;
   endfunction

   // Reference built from the requirement text.
   task automatic model(input logic [2:0] f, input logic [31:0] a, b, c,
                        output logic s, output longint e, output logic [63:0] m,
                        output logic [2:0] k, output logic sn, output logic bd,
                        output string tg);
      longint v;
      int p;
      int ex;
      logic [63:0] fr;
      s = a[31]; e = 0; m = '0; k = 3'd0; sn = 1'b0; bd = 1'b0; tg = "R4";
      case (f)
         3'd0, 3'd1, 3'd2: begin
            v = (f == 3'd0) ? longint'($signed(a[31:24])) :
                (f == 3'd1) ? longint'($signed(a[31:16])) : longint'($signed(a));
            if (v < 0) v = -v;
            if (v != 0) begin
               p = top_bit(64'(v));
               e = p; m = 64'(v) << (63 - p); k = 3'd1;
            end
         end
         3'd3, 3'd4: begin
            if (f == 3'd3) begin
               ex = int'(a[30:23]); fr = 64'(a[22:0]);
            end else begin
               ex = int'(a[30:20]); fr = {12'b0, a[19:0], b};
            end
            if (ex == 0) begin
               if (fr == 0) tg = "R7 R3";
               else begin
                  p = top_bit(fr);
                  e = (f == 3'd3) ? p - 149 : p - 1074;
                  m = fr << (63 - p); k = 3'd1; tg = "R6";
               end
            end else if (ex == ((f == 3'd3) ? 255 : 2047)) begin
               if (fr == 0) begin k = 3'd2; tg = "R8 R3"; end
               else begin
                  m = (f == 3'd3) ? (fr << 40) : (fr << 11);
                  if (!m[62]) begin m[62] = 1'b1; k = 3'd4; sn = 1'b1; tg = "R9"; end
                  else begin k = 3'd3; tg = "R8"; end
               end
            end else begin
               e = (f == 3'd3) ? ex - 127 : ex - 1023;
               m = (f == 3'd3) ? ((fr << 40) | 64'h8000_0000_0000_0000)
                               : ((fr << 11) | 64'h8000_0000_0000_0000);
               k = 3'd1; tg = "R5";
            end
         end
         3'd5: begin
            ex = int'(a[30:16]); fr = {b, c}; tg = "R10";
            if (ex == 0) begin
               if (fr != 0) begin
                  p = top_bit(fr);
                  e = p - 16446; m = fr << (63 - p); k = 3'd1;
               end
            end else if (ex == 32767) begin
               if (fr == 0) begin k = 3'd2; tg = "R10 R8"; end
               else begin
                  m = fr;
                  if (!m[62]) begin m[62] = 1'b1; k = 3'd4; sn = 1'b1; tg = "R9 R10"; end
                  else k = 3'd3;
               end
            end else begin
               e = ex - 16383; m = fr | 64'h8000_0000_0000_0000; k = 3'd1;
            end
         end
         default: begin bd = 1'b1; s = 1'b0; tg = "R2"; end
      endcase
   endtask

   task automatic run(input logic [2:0] f, input logic [31:0] a, b, c);
      logic s, sn, bd;
      longint e;
      logic [63:0] m;
      logic [2:0] k;
      string tg;
      @(negedge clk);
      fmt = f; w0 = a; w1 = b; w2 = c;
      @(negedge clk);
      model(f, a, b, c, s, e, m, k, sn, bd, tg);
      // R1 sign and sticky
      checks++;
      if (sign_o !== s || sticky_o !== 1'b0) begin
         errors++;
         $display("FAIL R1 fmt=%0d in=%h_%h_%h sign/sticky actual=%b/%b expected=%b/0",
                  f, a, b, c, sign_o, sticky_o, s);
      end
      checks++;
      if (longint'($signed(exp_o)) != e || mant_o !== m || cls_o !== k ||
          snan_flag_o !== sn || bad_fmt_o !== bd) begin
         errors++;
         $display("FAIL %s fmt=%0d in=%h_%h_%h actual exp=%0d mant=%h cls=%0d snan=%b bad=%b expected exp=%0d mant=%h cls=%0d snan=%b bad=%b",
                  tg, f, a, b, c, $signed(exp_o), mant_o, cls_o, snan_flag_o, bad_fmt_o,
                  e, m, k, sn, bd);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL R11 watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] sf [5];
      logic [31:0] dh [6];
      logic [31:0] dl [6];
      logic [63:0] xs [8];
      int de [8];
      int xe [5];
      sf = '{32'h0, 32'h1, 32'h40_0000, 32'h3F_FFFF, 32'h20_0001};
      dh = '{32'h0, 32'h0, 32'h8_0000, 32'h4_0000, 32'h0, 32'hF_FFFF};
      dl = '{32'h0, 32'h1, 32'h0, 32'h0, 32'h8000_0000, 32'hFFFF_FFFF};
      de = '{0, 1, 2, 1022, 1023, 1024, 2046, 2047};
      xe = '{0, 1, 16383, 32766, 32767};
      xs = '{64'h0, 64'h1, 64'h8000_0000_0000_0000, 64'h4000_0000_0000_0000,
             64'hC000_0000_0000_0000, 64'h3FFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0000,
             64'hFFFF_FFFF_FFFF_FFFF};
      rst_n = 1'b0; fmt = 3'd0; w0 = '0; w1 = '0; w2 = '0;
      repeat (3) @(negedge clk);
      fmt = 3'd5; w0 = 32'hFFFF_FFFF; w1 = 32'h1234_5678;
      @(negedge clk);
      // R11 reset holds every output at zero
      checks++;
      if (sign_o !== 1'b0 || exp_o !== '0 || mant_o !== '0 || cls_o !== 3'd0 ||
          snan_flag_o !== 1'b0 || bad_fmt_o !== 1'b0) begin
         errors++;
         $display("FAIL R11 reset outputs actual=%b_%h_%h_%0d_%b_%b expected=all zero",
                  sign_o, exp_o, mant_o, cls_o, snan_flag_o, bad_fmt_o);
      end
      rst_n = 1'b1;

      // R4 byte sweep, low bits carry junk
      for (int i = 0; i < 256; i++) run(3'd0, {i[7:0], 24'hA5C3_96 ^ 24'(i)}, 32'hFFFF_FFFF, 32'h0);
      // R4 word sweep
      for (int i = 0; i < 65536; i += 251) run(3'd1, {i[15:0], 16'h5A5A}, '0, '0);
      run(3'd1, 32'h8000_FFFF, '0, '0);
      run(3'd1, 32'h7FFF_0000, '0, '0);
      run(3'd1, 32'hFFFF_0000, '0, '0);
      // R4 long integers: powers of two, their negatives, and complements
      for (int i = 0; i < 32; i++) begin
         run(3'd2, 32'(1) << i, '0, '0);
         run(3'd2, -(32'(1) << i), '0, '0);
         run(3'd2, ~(32'(1) << i), '0, '0);
      end
      run(3'd2, 32'h0, '0, '0);
      // R5 R6 R7 R8 R9 single sweep over every exponent
      for (int e = 0; e < 256; e++)
         for (int j = 0; j < 5; j++) run(3'd3, {e[0], e[7:0], sf[j][22:0]}, 32'hDEAD_BEEF, '0);
      // R5 R6 R7 R8 R9 double corners
      for (int e = 0; e < 8; e++)
         for (int j = 0; j < 6; j++)
            run(3'd4, {1'(e), 11'(de[e]), dh[j][19:0]}, dl[j], 32'hFFFF_FFFF);
      // R10 extended corners, low word0 bits are ignored
      for (int e = 0; e < 5; e++)
         for (int j = 0; j < 8; j++)
            run(3'd5, {1'(j), 15'(xe[e]), 16'hBEEF}, xs[j][63:32], xs[j][31:0]);
      // R2 illegal codes
      run(3'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      run(3'd7, 32'h8000_0001, 32'h1, 32'h2);
      run(3'd7, 32'h7F80_0001, '0, '0);
      // R11 recovers with a legal code right after an illegal one
      run(3'd3, 32'hBF80_0000, '0, '0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule